// File: doc/BRIEF.md
# PCIe Configuration Access Shim

This block sits between a host-side 32-bit register access port and the configuration interface of a PCIe root port that does not fully follow the specification. Generic enumeration software can then treat that root port as compliant. The host presents an offset into a 256 MiB configuration window. The shim splits that offset into bus, device, function and register fields. It issues only aligned 32-bit transactions downstream, against either the ECAM base or a separately supplied root-port base.

Narrow host accesses are widened. A byte or halfword read becomes one word read, and the addressed lanes come back right-justified. A byte or halfword write becomes a word read, a lane merge and a word write. An error response from the root port is never passed on as a bus fault. On a read it becomes all-ones data with an OKAY completion. On a write it is absorbed silently. The shim handles one host transaction at a time, and it completes that transaction only after its whole downstream sequence has finished.

Top module: `pcie_cfg_shim`

## Requirements
- R1: When host offset bits [27:12] are not all zero, the downstream address is `ecam_base + {offset[27:2], 2'b00}`. The fields are bus [27:20], device [19:15], function [14:12] and register [11:0].
- R2: When bus, device and function are all zero, the downstream address is `root_base + {offset[11:2], 2'b00}`.
- R3: Every downstream request is a full 32-bit access with address bits [1:0] equal to zero. Its address and control stay stable while `dn_valid` is high and `dn_ready` is low.
- R4: Size codes are 0 for byte, 1 for halfword and 2 for word (3 is treated as word). A byte or halfword read issues exactly one downstream read. It returns the lanes starting at byte `offset[1:0]`, shifted to bit 0 and zero-extended.
- R5: A byte or halfword write issues one downstream read and then one downstream write. The write carries the read word with the low 8 or 16 bits of `host_req_wdata` placed into the lanes starting at byte `offset[1:0]`. All other lanes are unchanged.
- R6: A word access ignores `offset[1:0]`. A word write issues exactly one downstream write of `host_req_wdata` and no read.
- R7: A read that receives a downstream error completes with OKAY and read data 0xFFFFFFFF.
- R8: A write whose downstream write receives an error completes with OKAY.
- R9: If the read phase of a narrow write receives an error, no downstream write is issued, and the host gets OKAY.
- R10: A halfword access with `offset[0]` set completes with `host_rsp_err` high and issues no downstream request.
- R11: After reset no handshake or request is active. `host_req_ready` and `host_rsp_valid` pulse together for one cycle, only after the downstream sequence has ended. No downstream request is active in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecam_base | input | ADDR_W | Base address of the ECAM window |
| root_base | input | ADDR_W | Base address of the root port's own configuration space |
| host_req_valid | input | 1 | Host request present; held until `host_req_ready` |
| host_req_ready | output | 1 | Request accepted and completed (one-cycle pulse) |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| host_req_addr | input | 28 | Offset into the configuration window |
| host_req_wdata | input | 32 | Write data, right-justified for narrow writes |
| host_rsp_valid | output | 1 | Completion valid, same cycle as `host_req_ready` |
| host_rsp_err | output | 1 | Error completion (misaligned halfword only) |
| host_rsp_rdata | output | 32 | Read data, right-justified |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream request is a write |
| dn_addr | output | ADDR_W | Downstream word-aligned address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_err | input | 1 | Downstream error response |
| dn_rsp_rdata | input | 32 | Downstream read word |

## Verification
Root-port redirection and error absorption can act on the same transaction. The bench provokes this by making one register word of the root-port space answer with an error, so a narrow read there must both redirect to `root_base` and return 0xFFFFFFFF. A narrow write there must both redirect and skip its write phase. Extraction and all-ones substitution can also fall in the same response cycle of a narrow read to an absent device; all-ones must win. Each case is judged from the downstream address seen, the counts of downstream reads and writes, and the host completion data.

// File: rtl/pcie_cfg_shim_pkg.sv
package pcie_cfg_shim_pkg;

    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int ECAM_W   = 28;
    localparam int REG_W    = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [9:0] dword;
        logic [1:0] byte_ofs;
    } cfg_loc_t;

    function automatic logic is_full(input acc_size_e sz);
        return sz[1];
    endfunction

    function automatic logic [1:0] lane_shift(input acc_size_e sz, input logic [1:0] ofs);
        return is_full(sz) ? 2'd0 : ofs;
    endfunction

    function automatic logic [LANES-1:0] lane_enable(input acc_size_e sz, input logic [1:0] ofs);
        logic [LANES-1:0] base;
        case (sz)
            SZ_BYTE: base = 4'b0001;
            SZ_HALF: base = 4'b0011;
            default: base = 4'b1111;
        endcase
        return base << lane_shift(sz, ofs);
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic misaligned(input acc_size_e sz, input logic [1:0] ofs);
        return (sz == SZ_HALF) && ofs[0];
    endfunction

endpackage

// File: rtl/cfg_addr_map.sv
module cfg_addr_map
    import pcie_cfg_shim_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ECAM_W-1:0] ofs,
    input  logic [ADDR_W-1:0] ecam_base,
    input  logic [ADDR_W-1:0] root_base,
    output logic              is_root,
    output logic [ADDR_W-1:0] dn_addr
);
    cfg_loc_t          loc;
    logic [ADDR_W-1:0] rel;

    assign loc     = cfg_loc_t'(ofs);
    assign is_root = (loc.bus == '0) && (loc.dev == '0) && (loc.fn == '0);

    always_comb begin
        rel = '0;
        if (is_root) begin
            rel[REG_W-1:0] = {loc.dword, 2'b00};
        end else begin
            rel[ECAM_W-1:0] = {loc.bus, loc.dev, loc.fn, loc.dword, 2'b00};
        end
        dn_addr = (is_root ? root_base : ecam_base) + rel;
    end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
    import pcie_cfg_shim_pkg::*;
(
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_data,
    input  acc_size_e         size,
    input  logic [1:0]        ofs,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] extracted
);
    logic [1:0]        sh;
    logic [LANES-1:0]  en;
    logic [DATA_W-1:0] placed;

    assign sh        = lane_shift(size, ofs);
    assign en        = lane_enable(size, ofs);
    assign placed    = new_data << {sh, 3'b000};
    assign extracted = (old_word >> {sh, 3'b000}) & size_mask(size);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = en[i] ? placed[8*i +: 8] : old_word[8*i +: 8];
    end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import pcie_cfg_shim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req_valid,
    input  logic              host_req_write,
    input  acc_size_e         host_req_size,
    input  logic [ECAM_W-1:0] host_req_addr,
    input  logic [DATA_W-1:0] host_req_wdata,
    output logic              host_done,
    output logic              host_rsp_err,
    output logic [DATA_W-1:0] host_rsp_rdata,
    output logic [ECAM_W-1:0] cur_ofs,
    output acc_size_e         cur_size,
    output logic [DATA_W-1:0] cur_wdata,
    input  logic [DATA_W-1:0] merged,
    input  logic [DATA_W-1:0] extracted,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ready,
    input  logic              dn_rsp_valid,
    input  logic              dn_rsp_err
);
    seq_state_e        state;
    logic              wr_q;
    logic [DATA_W-1:0] wbuf;

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            wr_q           <= 1'b0;
            wbuf           <= '0;
            cur_ofs        <= '0;
            cur_size       <= SZ_WORD;
            cur_wdata      <= '0;
            host_rsp_err   <= 1'b0;
            host_rsp_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (host_req_valid) begin
                    cur_ofs        <= host_req_addr;
                    cur_size       <= host_req_size;
                    cur_wdata      <= host_req_wdata;
                    wr_q           <= host_req_write;
                    wbuf           <= host_req_wdata;
                    host_rsp_rdata <= '0;
                    host_rsp_err   <= 1'b0;
                    if (misaligned(host_req_size, host_req_addr[1:0])) begin
                        host_rsp_err <= 1'b1;
                        state        <= ST_DONE;
                    end else if (host_req_write && is_full(host_req_size)) begin
                        state <= ST_WR_REQ;
                    end else begin
                        state <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: if (dn_ready) state <= ST_RD_WAIT;
                ST_RD_WAIT: if (dn_rsp_valid) begin
                    if (dn_rsp_err) begin
                        host_rsp_rdata <= wr_q ? '0 : '1;
                        state          <= ST_DONE;
                    end else if (wr_q) begin
                        wbuf  <= merged;
                        state <= ST_WR_REQ;
                    end else begin
                        host_rsp_rdata <= extracted;
                        state          <= ST_DONE;
                    end
                end
                ST_WR_REQ:  if (dn_ready) state <= ST_WR_WAIT;
                ST_WR_WAIT: if (dn_rsp_valid) state <= ST_DONE;
                ST_DONE:    state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    assign host_done = (state == ST_DONE);
    assign dn_valid  = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    assign dn_write  = (state == ST_WR_REQ);
    assign dn_wdata  = wbuf;
endmodule

// File: rtl/pcie_cfg_shim.sv
module pcie_cfg_shim
    import pcie_cfg_shim_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ecam_base,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              host_req_valid,
    output logic              host_req_ready,
    input  logic              host_req_write,
    input  logic [1:0]        host_req_size,
    input  logic [27:0]       host_req_addr,
    input  logic [31:0]       host_req_wdata,
    output logic              host_rsp_valid,
    output logic              host_rsp_err,
    output logic [31:0]       host_rsp_rdata,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [31:0]       dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic              dn_rsp_err,
    input  logic [31:0]       dn_rsp_rdata
);
    logic              done;
    logic [ECAM_W-1:0] cur_ofs;
    acc_size_e         cur_size;
    logic [DATA_W-1:0] cur_wdata;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] extracted;
    logic              is_root;

    cfg_seq_ctrl u_seq (
        .clk            (clk),
        .rst            (rst),
        .host_req_valid (host_req_valid),
        .host_req_write (host_req_write),
        .host_req_size  (acc_size_e'(host_req_size)),
        .host_req_addr  (host_req_addr),
        .host_req_wdata (host_req_wdata),
        .host_done      (done),
        .host_rsp_err   (host_rsp_err),
        .host_rsp_rdata (host_rsp_rdata),
        .cur_ofs        (cur_ofs),
        .cur_size       (cur_size),
        .cur_wdata      (cur_wdata),
        .merged         (merged),
        .extracted      (extracted),
        .dn_valid       (dn_valid),
        .dn_write       (dn_write),
        .dn_wdata       (dn_wdata),
        .dn_ready       (dn_ready),
        .dn_rsp_valid   (dn_rsp_valid),
        .dn_rsp_err     (dn_rsp_err)
    );

    cfg_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .ofs       (cur_ofs),
        .ecam_base (ecam_base),
        .root_base (root_base),
        .is_root   (is_root),
        .dn_addr   (dn_addr)
    );

    cfg_lane_unit u_lane (
        .old_word  (dn_rsp_rdata),
        .new_data  (cur_wdata),
        .size      (cur_size),
        .ofs       (cur_ofs[1:0]),
        .merged    (merged),
        .extracted (extracted)
    );

    assign host_req_ready = done;
    assign host_rsp_valid = done;
endmodule

// File: rtl/pcie_cfg_shim_chk.sv
module pcie_cfg_shim_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] root_base,
    input logic              host_req_valid,
    input logic              host_req_ready,
    input logic              host_req_write,
    input logic [1:0]        host_req_size,
    input logic [27:0]       host_req_addr,
    input logic              host_rsp_valid,
    input logic              host_rsp_err,
    input logic [31:0]       host_rsp_rdata,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic              dn_write,
    input logic [ADDR_W-1:0] dn_addr,
    input logic              dn_rsp_valid,
    input logic              dn_rsp_err
);
    logic last_wr;
    logic host_mis;
    logic [ADDR_W-1:0] root_exp;

    always_ff @(posedge clk) begin
        if (rst) last_wr <= 1'b0;
        else if (dn_valid && dn_ready) last_wr <= dn_write;
    end

    assign host_mis = (host_req_size == 2'd1) && host_req_addr[0];
    always_comb begin
        root_exp = '0;
        root_exp[11:0] = {host_req_addr[11:2], 2'b00};
        root_exp = root_exp + root_base;
    end

    // R3
    dn_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (dn_addr[1:0] == 2'b00));

    // R3
    dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write)));

    // R2
    root_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && host_req_valid && (host_req_addr[27:12] == 16'd0)) |-> (dn_addr == root_exp));

    // R7
    rd_err_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_rsp_valid && dn_rsp_err && !last_wr && !host_req_write)
            |=> (host_rsp_valid && !host_rsp_err && (host_rsp_rdata == 32'hFFFF_FFFF)));

    // R9
    rmw_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_rsp_valid && dn_rsp_err && !last_wr && host_req_write) |=> host_rsp_valid);

    // R10
    misaligned_err_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rsp_valid && host_req_valid && host_mis) |-> host_rsp_err);

    // R8
    absorb_err_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rsp_valid && host_req_valid && !host_mis) |-> !host_rsp_err);

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_rsp_valid |=> !host_rsp_valid);

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        host_rsp_valid |-> (!dn_valid && host_req_ready));
endmodule

bind pcie_cfg_shim pcie_cfg_shim_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .root_base      (root_base),
    .host_req_valid (host_req_valid),
    .host_req_ready (host_req_ready),
    .host_req_write (host_req_write),
    .host_req_size  (host_req_size),
    .host_req_addr  (host_req_addr),
    .host_rsp_valid (host_rsp_valid),
    .host_rsp_err   (host_rsp_err),
    .host_rsp_rdata (host_rsp_rdata),
    .dn_valid       (dn_valid),
    .dn_ready       (dn_ready),
    .dn_write       (dn_write),
    .dn_addr        (dn_addr),
    .dn_rsp_valid   (dn_rsp_valid),
    .dn_rsp_err     (dn_rsp_err)
);

// File: tb/pcie_cfg_shim_tb_top.sv
module pcie_cfg_shim_tb_top;
    localparam logic [31:0] ECAM_B = 32'h4000_0000;
    localparam logic [31:0] ROOT_B = 32'h6000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req_valid = 1'b0;
    logic        host_req_ready;
    logic        host_req_write = 1'b0;
    logic [1:0]  host_req_size = 2'd2;
    logic [27:0] host_req_addr = '0;
    logic [31:0] host_req_wdata = '0;
    logic        host_rsp_valid;
    logic        host_rsp_err;
    logic [31:0] host_rsp_rdata;
    logic        dn_valid;
    logic        dn_ready = 1'b0;
    logic        dn_write;
    logic [31:0] dn_addr;
    logic [31:0] dn_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic        dn_rsp_err = 1'b0;
    logic [31:0] dn_rsp_rdata = '0;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int addr_bad = 0;
    logic [31:0] exp_addr = '0;
    logic [31:0] mem [0:47];
    logic [31:0] refm [0:47];

    always #2 clk = ~clk;

    pcie_cfg_shim #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst(rst), .ecam_base(ECAM_B), .root_base(ROOT_B),
        .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
        .host_req_write(host_req_write), .host_req_size(host_req_size),
        .host_req_addr(host_req_addr), .host_req_wdata(host_req_wdata),
        .host_rsp_valid(host_rsp_valid), .host_rsp_err(host_rsp_err),
        .host_rsp_rdata(host_rsp_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Downstream responder: root space words 0..15 (word 3 answers with an error),
    // ECAM bus 1 devices 0 and 1 function 0 words 0..15; everything else is absent.
    task automatic lookup(input logic [31:0] a, output int idx, output logic err);
        logic [31:0] off;
        err = 1'b1;
        idx = 0;
        if (a - ROOT_B < 32'd64) begin
            idx = int'((a - ROOT_B) >> 2);
            err = (idx == 3);
        end else begin
            off = a - ECAM_B;
            if (off[31:28] == 0 && off[27:20] == 8'd1 && off[19:15] < 5'd2 &&
                off[14:12] == 3'd0 && off[11:6] == 6'd0) begin
                idx = 16 * (int'(off[19:15]) + 1) + int'(off[5:2]);
                err = 1'b0;
            end
        end
    endtask

    initial begin : responder
        int lat = 0;
        int idx;
        logic err;
        logic [31:0] a;
        logic w;
        logic [31:0] d;
        forever begin
            @(negedge clk);
            dn_rsp_valid = 1'b0;
            if (dn_valid) begin
                dn_ready = 1'b1;
                a = dn_addr; w = dn_write; d = dn_wdata;
                if (a != exp_addr) addr_bad++;
                @(negedge clk);
                dn_ready = 1'b0;
                repeat (lat) @(negedge clk);
                lookup(a, idx, err);
                if (w) begin
                    wr_cnt++;
                    if (!err) mem[idx] = d;
                    dn_rsp_rdata = 32'hDEAD_0000;
                end else begin
                    rd_cnt++;
                    dn_rsp_rdata = err ? 32'h0BAD_0BAD : mem[idx];
                end
                dn_rsp_err   = err;
                dn_rsp_valid = 1'b1;
                lat = (lat + 1) % 3;
            end
        end
    end

    task automatic run_one(input int t, input int wd, input int s, input int o, input int w, input int n);
        logic [15:0] bdf;
        logic        present;
        logic        mis;
        int          ridx;
        int          sh;
        logic [31:0] mask, wdat, exp_rd, got_rd;
        logic        got_err;
        int          exp_r, exp_w;
        case (t)
            0: bdf = 16'h0000;
            1: bdf = {8'd1, 5'd0, 3'd0};
            2: bdf = {8'd1, 5'd1, 3'd0};
            3: bdf = {8'd1, 5'd2, 3'd0};
            default: bdf = {8'd0, 5'd0, 3'd1};
        endcase
        present = (t == 0 && wd != 3) || t == 1 || t == 2;
        ridx    = t * 16 + wd;
        mis     = (s == 1) && (o % 2 == 1);
        sh      = (s == 2) ? 0 : o * 8;
        mask    = (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        wdat    = 32'h5A00_0000 ^ (32'(n) * 32'h9E37_79B1);
        exp_addr = (t == 0) ? ROOT_B + 32'(wd * 4) : ECAM_B + {4'd0, bdf, 12'(wd * 4)};
        exp_rd  = 32'h0;
        exp_r   = 0;
        exp_w   = 0;
        if (!mis) begin
            if (w == 0) begin
                exp_r  = 1;
                exp_rd = present ? ((refm[ridx] >> sh) & mask) : 32'hFFFF_FFFF;
            end else if (s == 2) begin
                exp_w = 1;
                if (present) refm[ridx] = wdat;
            end else begin
                exp_r = 1;
                exp_w = present ? 1 : 0;
                if (present) refm[ridx] = (refm[ridx] & ~(mask << sh)) | ((wdat & mask) << sh);
            end
        end
        rd_cnt = 0; wr_cnt = 0; addr_bad = 0;
        @(negedge clk);
        host_req_valid = 1'b1;
        host_req_write = (w != 0);
        host_req_size  = 2'(s);
        host_req_addr  = {bdf, 12'(wd * 4 + o)};
        host_req_wdata = wdat;
        do @(negedge clk); while (!host_rsp_valid);
        got_err = host_rsp_err;
        got_rd  = host_rsp_rdata;
        @(negedge clk);
        host_req_valid = 1'b0;
        if (mis) begin
            chk(got_err == 1'b1, "R10 misaligned err", 32'(got_err), 32'd1);
            chk(rd_cnt + wr_cnt == 0, "R10 no downstream", 32'(rd_cnt + wr_cnt), 32'd0);
        end else begin
            chk(got_err == 1'b0, w ? "R8 write completes OKAY" : "R7 read completes OKAY", 32'(got_err), 32'd0);
            chk(addr_bad == 0, t == 0 ? "R2 root redirect addr" : "R1 ECAM addr", 32'(addr_bad), 32'd0);
            chk(rd_cnt == exp_r, s == 2 ? "R6 word read count" : "R4_R5_R9 read count", 32'(rd_cnt), 32'(exp_r));
            chk(wr_cnt == exp_w, (s != 2 && !present) ? "R9 write skipped" : "R5_R6 write count", 32'(wr_cnt), 32'(exp_w));
            if (w == 0)
                chk(got_rd == exp_rd, present ? "R4 extracted data" : "R7 all ones", got_rd, exp_rd);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int n = 0;
        for (int i = 0; i < 48; i++) begin
            mem[i]  = 32'hC0DE_0000 + 32'(i) * 32'h0001_0203;
            refm[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(host_req_ready == 1'b0, "R11 reset ready", 32'(host_req_ready), 32'd0);
        chk(host_rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(host_rsp_valid), 32'd0);
        chk(dn_valid == 1'b0, "R11 reset dn_valid", 32'(dn_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int pass = 0; pass < 2; pass++)
            for (int t = 0; t < 5; t++)
                for (int wd = 0; wd < 4; wd++)
                    for (int s = 0; s < 3; s++)
                        for (int o = 0; o < 4; o++)
                            for (int w = 0; w < 2; w++) begin
                                run_one(t, wd, s, o, w, n);
                                n++;
                            end
        // R5 R3: final contents seen by the root port match merged expectations
        for (int i = 0; i < 48; i++)
            chk(mem[i] === refm[i], "R5 final word", mem[i], refm[i]);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule